// File: doc/BRIEF.md
# Stored Wiper Setting Register Bank

This block holds the saved settings for a pair of digital potentiometers: one small bank of data words per pot, each word six bits wide. A serial front end, decoded elsewhere, hands it host writes, wiper saves and transfer requests as single-cycle strobes. Host reads and transfers into the wiper registers are served at once. Every change to the bank is first staged. It becomes a timed store only when the bus stop condition arrives, and the new value lands in the bank only at the end of that store.

While a store runs, `busy` stays high so that the front end can refuse to acknowledge its address. Staged stores are discarded by a fresh start condition, or dropped without effect when the write-protect input is low at the stop. After reset the block sends word 0 of every pot to its wiper register, which is the power-up setting. The bank contents survive reset.

Top module: `nvreg_bank_ctrl`

## Requirements
- R1: While `rst` is high, `busy`, `xfr_valid` and `rd_data` are zero. After the first clock edge with `rst` low, `xfr_valid` is all ones for one cycle and each pot's slice of `xfr_data` carries that pot's word 0. Reset does not alter the bank, which starts out holding `INIT_WORD` in every word.
- R2: A cycle with `rd_req` high loads `rd_data` at the next edge with word `rd_idx` of pot `rd_pot`. `rd_data` holds its value in every cycle without `rd_req`.
- R3: `st_kind` = 0 (host write) stages `st_wdata` for word `st_idx` of pot `st_pot`. The word changes only when a later stop completes the store.
- R4: `st_kind` = 1 (single save) stages the wiper value of pot `st_pot`, taken from `wiper_pos` in the cycle of `st_req`, for word `st_idx` of that pot. Pot n occupies bits [6n+5:6n] of every packed pot vector.
- R5: `st_kind` = 2 (global save) stages every pot's wiper value for word `st_idx` of its own pot.
- R6: A `bus_stop` that finds a staged store with `wp_n` high raises `busy` at the next edge, and `busy` stays high for exactly `STORE_CYC` cycles. The bank takes the new value at the edge where `busy` falls. Until then, reads return the old value.
- R7: A `bus_stop` with `wp_n` low discards the staged store. `busy` stays low and the bank is unchanged.
- R8: A `bus_start` discards any staged store. A `bus_stop` with nothing staged does not raise `busy`.
- R9: While `busy` is high, `st_req` and `bus_stop` have no effect.
- R10: `rcl_req` sets `xfr_valid` for one cycle at the next edge and loads `xfr_data` from word `rcl_idx`. It covers only pot `rcl_pot` when `rcl_glob` is 0, and every pot when `rcl_glob` is 1.
- R11: `st_kind` = 3 stages nothing. A following stop leaves `busy` low and the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write protect, low blocks stores |
| bus_start | input | 1 | Start condition seen, one-cycle strobe |
| bus_stop | input | 1 | Stop condition seen, one-cycle strobe |
| rd_req | input | 1 | Host read strobe |
| rd_pot | input | PW | Pot selected for the read |
| rd_idx | input | IW | Word selected for the read |
| rd_data | output | DW | Registered read result |
| st_req | input | 1 | Stage a store, one-cycle strobe |
| st_kind | input | 2 | 0 host write, 1 single save, 2 global save, 3 none |
| st_pot | input | PW | Pot for a host write or single save |
| st_idx | input | IW | Target word of the store |
| st_wdata | input | DW | Host write data |
| wiper_pos | input | NPOT*DW | Current wiper value of every pot, packed |
| rcl_req | input | 1 | Transfer strobe, word to wiper register |
| rcl_glob | input | 1 | Transfer into every pot |
| rcl_pot | input | PW | Pot for a single transfer |
| rcl_idx | input | IW | Source word of the transfer |
| xfr_valid | output | NPOT | Per-pot transfer strobe |
| xfr_data | output | NPOT*DW | Per-pot transfer value, packed |
| busy | output | 1 | Store cycle in progress |

## Verification
The assertions assume that the front end raises `bus_start`, `bus_stop`, `st_req`, `rd_req` and `rcl_req` only as single-cycle strobes. They also assume it never raises `st_req` and `bus_stop` in the same cycle, since a data byte always completes before its stop. The bench drives each strobe for exactly one cycle from the falling clock edge and keeps each stage strictly ahead of its stop. When it probes R9, it raises strobes during `busy` on purpose. Those strobes fall in the window that the assertions treat as ignored, so they stay inside the same assumptions.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [1:0] {
    ST_HOST  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_GSAVE = 2'd2,
    ST_NONE  = 2'd3
  } st_kind_e;
endpackage

// File: rtl/nvb_bank.sv
module nvb_bank #(
  parameter int DW        = 6,
  parameter int NREG      = 4,
  parameter int INIT_WORD = 0,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem [NREG];

  // Power-on content; reset deliberately leaves the array alone.
  initial begin
    for (int i = 0; i < NREG; i++) mem[i] = DW'(INIT_WORD);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/nvb_store_timer.sv
module nvb_store_timer #(
  parameter int STORE_CYC = 250000,
  localparam int CW = $clog2(STORE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(STORE_CYC - 1);
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/nvb_stage.sv
module nvb_stage
  import nvb_pkg::*;
#(
  parameter int DW   = 6,
  parameter int NREG = 4,
  parameter int NPOT = 2,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               clear,
  input  logic [1:0]         kind,
  input  logic [PW-1:0]      pot,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      wdata,
  input  logic [NPOT*DW-1:0] wiper_pos,
  output logic               stg_vld,
  output logic [NPOT-1:0]    stg_mask,
  output logic [IW-1:0]      stg_idx,
  output logic [NPOT*DW-1:0] stg_data
);
  st_kind_e k;
  logic     take;

  assign k    = st_kind_e'(kind);
  assign take = accept && !clear && (k != ST_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld <= 1'b0;
      stg_idx <= '0;
    end else if (clear) begin
      stg_vld <= 1'b0;
    end else if (take) begin
      stg_vld <= 1'b1;
      stg_idx <= idx;
    end
  end

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic sel;
    assign sel = (k == ST_GSAVE) || (pot == PW'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_mask[p]            <= 1'b0;
        stg_data[p*DW +: DW]   <= '0;
      end else if (take) begin
        stg_mask[p]            <= sel;
        stg_data[p*DW +: DW]   <= (k == ST_HOST) ? wdata : wiper_pos[p*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/nvreg_bank_ctrl.sv
module nvreg_bank_ctrl #(
  parameter int DW        = 6,
  parameter int NREG      = 4,
  parameter int NPOT      = 2,
  parameter int STORE_CYC = 250000,
  parameter int INIT_WORD = 0,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wp_n,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               rd_req,
  input  logic [PW-1:0]      rd_pot,
  input  logic [IW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data,
  input  logic               st_req,
  input  logic [1:0]         st_kind,
  input  logic [PW-1:0]      st_pot,
  input  logic [IW-1:0]      st_idx,
  input  logic [DW-1:0]      st_wdata,
  input  logic [NPOT*DW-1:0] wiper_pos,
  input  logic               rcl_req,
  input  logic               rcl_glob,
  input  logic [PW-1:0]      rcl_pot,
  input  logic [IW-1:0]      rcl_idx,
  output logic [NPOT-1:0]    xfr_valid,
  output logic [NPOT*DW-1:0] xfr_data,
  output logic               busy
);
  logic               stg_vld;
  logic [NPOT-1:0]    stg_mask;
  logic [IW-1:0]      stg_idx;
  logic [NPOT*DW-1:0] stg_data;
  logic               stop_ok;
  logic               commit;
  logic               done;
  logic               boot_q;
  logic [IW-1:0]      xfr_addr;
  logic [DW-1:0]      rd_word [NPOT];
  logic [DW-1:0]      xf_word [NPOT];

  assign stop_ok  = bus_stop && !busy;
  assign commit   = stop_ok && stg_vld && wp_n;
  assign xfr_addr = boot_q ? '0 : rcl_idx;

  nvb_stage #(.DW(DW), .NREG(NREG), .NPOT(NPOT)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .accept    (st_req && !busy),
    .clear     (bus_start || stop_ok),
    .kind      (st_kind),
    .pot       (st_pot),
    .idx       (st_idx),
    .wdata     (st_wdata),
    .wiper_pos (wiper_pos),
    .stg_vld   (stg_vld),
    .stg_mask  (stg_mask),
    .stg_idx   (stg_idx),
    .stg_data  (stg_data)
  );

  nvb_store_timer #(.STORE_CYC(STORE_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (commit),
    .busy  (busy),
    .done  (done)
  );

  for (genvar p = 0; p < NPOT; p++) begin : g_bank
    nvb_bank #(.DW(DW), .NREG(NREG), .INIT_WORD(INIT_WORD)) u_bank (
      .clk     (clk),
      .we      (done && stg_mask[p]),
      .waddr   (stg_idx),
      .wdata   (stg_data[p*DW +: DW]),
      .ra_addr (rd_idx),
      .ra_data (rd_word[p]),
      .rb_addr (xfr_addr),
      .rb_data (xf_word[p])
    );

    logic hit;
    assign hit = boot_q || (rcl_req && (rcl_glob || (rcl_pot == PW'(p))));

    always_ff @(posedge clk) begin
      if (rst) begin
        xfr_valid[p]          <= 1'b0;
        xfr_data[p*DW +: DW]  <= '0;
      end else begin
        xfr_valid[p] <= hit;
        if (hit) xfr_data[p*DW +: DW] <= xf_word[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q  <= 1'b1;
      rd_data <= '0;
    end else begin
      boot_q <= 1'b0;
      if (rd_req) rd_data <= rd_word[rd_pot];
    end
  end
endmodule

// File: rtl/nvb_checker.sv
module nvb_checker #(
  parameter int DW        = 6,
  parameter int NPOT      = 2,
  parameter int STORE_CYC = 250000
) (
  input logic            clk,
  input logic            rst,
  input logic            wp_n,
  input logic            bus_stop,
  input logic            rd_req,
  input logic [DW-1:0]   rd_data,
  input logic            busy,
  input logic            stg_vld,
  input logic            boot_q,
  input logic            rcl_req,
  input logic [NPOT-1:0] xfr_valid
);
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R6: a store never outlasts its window
  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < 32'(STORE_CYC)));

  // R6: a store always fills its whole window
  a_r6_busy_full: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == 32'(STORE_CYC)));

  // R8: busy only ever starts from a stop that met a staged store
  a_r8_busy_from_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_stop && stg_vld));

  // R7: protected stop leaves the block idle
  a_r7_protect_idle: assert property (@(posedge clk) disable iff (rst)
    (bus_stop && !wp_n && !busy) |=> !busy);

  // R2: read result holds without a read strobe
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));

  // R10: transfer strobes have a cause
  a_r10_xfr_cause: assert property (@(posedge clk) disable iff (rst)
    (|xfr_valid) |-> $past(rcl_req || boot_q));
endmodule

bind nvreg_bank_ctrl nvb_checker #(
  .DW(DW), .NPOT(NPOT), .STORE_CYC(STORE_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wp_n      (wp_n),
  .bus_stop  (bus_stop),
  .rd_req    (rd_req),
  .rd_data   (rd_data),
  .busy      (busy),
  .stg_vld   (stg_vld),
  .boot_q    (boot_q),
  .rcl_req   (rcl_req),
  .xfr_valid (xfr_valid)
);

// File: tb/nvreg_bank_ctrl_tb.sv
module nvreg_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 6;
  localparam int NREG = 4;
  localparam int NPOT = 2;
  localparam int SC = 6;
  localparam int INIT = 'h15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_n = 1'b1;
  logic bus_start = 1'b0, bus_stop = 1'b0;
  logic rd_req = 1'b0;
  logic [0:0] rd_pot = '0;
  logic [1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic st_req = 1'b0;
  logic [1:0] st_kind = '0;
  logic [0:0] st_pot = '0;
  logic [1:0] st_idx = '0;
  logic [DW-1:0] st_wdata = '0;
  logic [NPOT*DW-1:0] wiper_pos = '0;
  logic rcl_req = 1'b0, rcl_glob = 1'b0;
  logic [0:0] rcl_pot = '0;
  logic [1:0] rcl_idx = '0;
  logic [NPOT-1:0] xfr_valid;
  logic [NPOT*DW-1:0] xfr_data;
  logic busy;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] expm [NPOT][NREG];

  // {pot, idx, data}
  localparam logic [8:0] TBL [6] = '{
    {1'b0, 2'd0, 6'h2A}, {1'b1, 2'd3, 6'h3F}, {1'b0, 2'd2, 6'h00},
    {1'b1, 2'd0, 6'h01}, {1'b0, 2'd3, 6'h30}, {1'b1, 2'd1, 6'h0C}
  };

  nvreg_bank_ctrl #(.DW(DW), .NREG(NREG), .NPOT(NPOT), .STORE_CYC(SC), .INIT_WORD(INIT)) u_dut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rd_req(rd_req), .rd_pot(rd_pot), .rd_idx(rd_idx), .rd_data(rd_data),
    .st_req(st_req), .st_kind(st_kind), .st_pot(st_pot), .st_idx(st_idx),
    .st_wdata(st_wdata), .wiper_pos(wiper_pos), .rcl_req(rcl_req),
    .rcl_glob(rcl_glob), .rcl_pot(rcl_pot), .rcl_idx(rcl_idx),
    .xfr_valid(xfr_valid), .xfr_data(xfr_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input int p, input int i, output int v);
    rd_req = 1'b1; rd_pot = 1'(p); rd_idx = 2'(i);
    tick(1);
    rd_req = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic stage(input int kind, input int p, input int i, input int d);
    st_req = 1'b1; st_kind = 2'(kind); st_pot = 1'(p); st_idx = 2'(i); st_wdata = 6'(d);
    tick(1);
    st_req = 1'b0;
  endtask

  task automatic stop_count(output int n);
    bus_stop = 1'b1;
    tick(1);
    bus_stop = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      tick(1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, n;
    for (int p = 0; p < NPOT; p++)
      for (int i = 0; i < NREG; i++) expm[p][i] = 6'(INIT);

    tick(3);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 xfr_valid in reset", int'(xfr_valid), 0);
    chk("R1 rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;
    tick(1);
    chk("R1 boot valid", int'(xfr_valid), 3);
    chk("R1 boot pot0", int'(xfr_data[5:0]), INIT);
    chk("R1 boot pot1", int'(xfr_data[11:6]), INIT);
    tick(1);
    chk("R1 boot one cycle", int'(xfr_valid), 0);

    // table walk: host writes, store length, read back
    for (int t = 0; t < 6; t++) begin
      int p, i, d;
      p = int'(TBL[t][8]); i = int'(TBL[t][7:6]); d = int'(TBL[t][5:0]);
      stage(0, p, i, d);
      do_read(p, i, v);
      chk("R3 no change before stop", v, int'(expm[p][i]));
      stop_count(n);
      chk("R6 busy length", n, SC);
      expm[p][i] = 6'(d);
      do_read(p, i, v);
      chk("R3 write landed", v, d);
    end
    tick(3);
    chk("R2 rd_data held", int'(rd_data), int'(expm[1][1]));

    // R6: reads during busy see the old word
    stage(0, 0, 1, 'h3C);
    bus_stop = 1'b1; tick(1); bus_stop = 1'b0;
    chk("R6 busy after stop", int'(busy), 1);
    do_read(0, 1, v);
    chk("R6 old value during busy", v, int'(expm[0][1]));
    while (busy) tick(1);
    expm[0][1] = 6'h3C;
    do_read(0, 1, v);
    chk("R6 new value after busy", v, 'h3C);

    // R4: single save captures wiper at st_req
    wiper_pos = {6'h07, 6'h22};
    stage(1, 1, 2, 0);
    wiper_pos = {6'h11, 6'h11};
    stop_count(n);
    expm[1][2] = 6'h07;
    do_read(1, 2, v);
    chk("R4 single save", v, 'h07);
    do_read(0, 2, v);
    chk("R4 other pot untouched", v, int'(expm[0][2]));

    // R5: global save
    wiper_pos = {6'h2B, 6'h19};
    stage(2, 0, 3, 0);
    stop_count(n);
    chk("R5 global busy length", n, SC);
    expm[0][3] = 6'h19; expm[1][3] = 6'h2B;
    do_read(0, 3, v);
    chk("R5 global pot0", v, 'h19);
    do_read(1, 3, v);
    chk("R5 global pot1", v, 'h2B);

    // R7: write protect drops the store
    wp_n = 1'b0;
    stage(0, 1, 0, 'h2D);
    stop_count(n);
    chk("R7 no busy when protected", n, 0);
    wp_n = 1'b1;
    tick(1);
    chk("R7 busy stays low", int'(busy), 0);
    do_read(1, 0, v);
    chk("R7 bank unchanged", v, int'(expm[1][0]));

    // R8: start discards stage; bare stop is harmless
    stage(0, 0, 0, 'h0F);
    bus_start = 1'b1; tick(1); bus_start = 1'b0;
    stop_count(n);
    chk("R8 start discards stage", n, 0);
    do_read(0, 0, v);
    chk("R8 bank unchanged", v, int'(expm[0][0]));

    // R9: requests during busy ignored
    stage(0, 0, 2, 'h05);
    bus_stop = 1'b1; tick(1); bus_stop = 1'b0;
    stage(0, 1, 1, 'h33);
    bus_stop = 1'b1; tick(1); bus_stop = 1'b0;
    while (busy) tick(1);
    expm[0][2] = 6'h05;
    tick(2);
    chk("R9 no second store", int'(busy), 0);
    do_read(1, 1, v);
    chk("R9 bank unchanged", v, int'(expm[1][1]));
    do_read(0, 2, v);
    chk("R9 first store landed", v, 'h05);

    // R10: transfers
    rcl_req = 1'b1; rcl_glob = 1'b0; rcl_pot = 1'b1; rcl_idx = 2'd3;
    tick(1);
    rcl_req = 1'b0;
    chk("R10 single valid", int'(xfr_valid), 2);
    chk("R10 single data", int'(xfr_data[11:6]), int'(expm[1][3]));
    rcl_req = 1'b1; rcl_glob = 1'b1; rcl_idx = 2'd1;
    tick(1);
    rcl_req = 1'b0; rcl_glob = 1'b0;
    chk("R10 global valid", int'(xfr_valid), 3);
    chk("R10 global pot0", int'(xfr_data[5:0]), int'(expm[0][1]));
    chk("R10 global pot1", int'(xfr_data[11:6]), int'(expm[1][1]));
    tick(1);
    chk("R10 one cycle", int'(xfr_valid), 0);

    // R11: kind 3 stages nothing
    stage(3, 0, 0, 'h3A);
    stop_count(n);
    chk("R11 no store", n, 0);
    do_read(0, 0, v);
    chk("R11 bank unchanged", v, int'(expm[0][0]));

    // R1: bank survives reset, boot recalls word 0
    rst = 1'b1; tick(2); rst = 1'b0;
    tick(1);
    chk("R1 boot after reset valid", int'(xfr_valid), 3);
    chk("R1 boot keeps pot0 word0", int'(xfr_data[5:0]), int'(expm[0][0]));
    chk("R1 boot keeps pot1 word0", int'(xfr_data[11:6]), int'(expm[1][0]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule